// File: doc/BRIEF.md
# Set/clear/toggle alias register bank

This block is the control and status register file of a clock and power controller. It decodes a word-wide memory-mapped bus into two groups of 32-bit registers. The lower half of a 32 KB byte window holds the digital clock-control group, whose registers are written directly. The upper half holds the analog/PLL group. There, every register takes four consecutive word addresses: the register itself, then a set alias, a clear alias and a toggle alias. Software can change single bits through an alias without a read-modify-write sequence.

Each register has a protection mask of read-only bits. No write path can change these bits. At reset, each register loads its own fixed value from a parameter. The first few analog registers are PLL control registers: their lock status bit is forced to 1 at reset and is always protected. Reads are combinational. Writes take effect on the next clock edge. An access that falls outside the implemented registers does nothing and answers with a one-cycle error pulse.

Top module: `regbank_sct`

## Requirements
- R1: The byte address `addr` selects a word as `addr>>2`, and `addr[1:0]` is ignored. `addr[14]`=0 selects the digital group, with register index `addr[13:2]`. `addr[14]`=1 selects the analog group, with register index `addr[13:4]` and access kind `addr[3:2]`: 0 selects the base register, 1 the set alias, 2 the clear alias and 3 the toggle alias.
- R2: Reset loads each register from its parameter value. Digital register i takes `DIG_INIT[i*32 +: 32]` and analog register j takes `ANA_INIT[j*32 +: 32]`. For analog register j with j < `N_PLL`, bit `LOCK_BIT` is also forced to 1.
- R3: A write with `req`=`we`=1 to a base register sets it to (old & mask) | (wdata & ~mask). The mask of digital register i is `DIG_MASK[i*32 +: 32]`. The mask of analog register j is `ANA_MASK[j*32 +: 32]`, with bit `LOCK_BIT` added when j < `N_PLL`. An all-ones mask gives a fully read-only register and an all-zero mask gives a fully writable one.
- R4: A set-alias write does reg |= wdata & ~mask.
- R5: A clear-alias write does reg &= ~(wdata & ~mask).
- R6: A toggle-alias write does reg ^= wdata & ~mask.
- R7: A read of any alias word returns the current value of its base register.
- R8: The lock bit of a PLL register stays 1 after every kind of write.
- R9: An address beyond the last register of its group reads as 0. A write to such an address changes no register.
- R10: `err` is 1 in the cycle after a cycle with `req`=1 to an unmapped address, and 0 in every other cycle, including after reset.
- R11: In the cycle of a write, `rdata` for the same address shows the old value. The new value is visible after the clock edge.
- R12: With `req`=0, `we` and `wdata` change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access valid this cycle |
| we | input | 1 | Write when 1, read when 0 |
| addr | input | ADDR_W (15) | Byte address in the window |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data, combinational from addr |
| err | output | 1 | One-cycle pulse after an unmapped access |

## Verification
The bench builds the bank with eight digital registers and six analog registers, three of which are PLL registers with the lock flag in bit 31. The mask and reset vectors are its own. They include an all-ones status register, an all-zero gate register and mixed patterns, so the protected-bit merge is exercised on every alias kind. Random register indices run a few entries past the end of both groups, which exercises the zero read, the ignored write and the error pulse. The lock bit is attacked with clear, toggle and direct writes.

// File: rtl/regbank_sct.sv
`timescale 1ns/1ps
module regbank_sct #(
  parameter int DW       = 32,
  parameter int ADDR_W   = 15,
  parameter int N_DIG    = 8,
  parameter int N_ANA    = 6,
  parameter int N_PLL    = 3,
  parameter int LOCK_BIT = 31,
  parameter logic [N_DIG*DW-1:0] DIG_INIT = '0,
  parameter logic [N_DIG*DW-1:0] DIG_MASK = '0,
  parameter logic [N_ANA*DW-1:0] ANA_INIT = '0,
  parameter logic [N_ANA*DW-1:0] ANA_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              err
);
  localparam int DI_W = ADDR_W - 3;
  localparam int AR_W = ADDR_W - 5;
  localparam logic [DW-1:0] LOCK = DW'(1) << LOCK_BIT;

  logic [N_DIG-1:0][DW-1:0] dig_q;
  logic [N_ANA-1:0][DW-1:0] ana_q;

  wire            is_ana  = addr[ADDR_W-1];
  wire [DI_W-1:0] dsel    = addr[ADDR_W-2:2];
  wire [AR_W-1:0] asel    = addr[ADDR_W-2:4];
  wire [1:0]      kind    = addr[3:2];
  wire            dig_hit = !is_ana && (dsel < DI_W'(N_DIG));
  wire            ana_hit = is_ana && (asel < AR_W'(N_ANA));
  wire            wr      = req && we;

  function automatic logic [DW-1:0] amask(int j);
    return ANA_MASK[j*DW +: DW] | ((j < N_PLL) ? LOCK : '0);
  endfunction

  function automatic logic [DW-1:0] ainit(int j);
    return ANA_INIT[j*DW +: DW] | ((j < N_PLL) ? LOCK : '0);
  endfunction

  function automatic logic [DW-1:0] anext(logic [DW-1:0] q, logic [DW-1:0] m,
                                          logic [DW-1:0] d, logic [1:0] k);
    logic [DW-1:0] u;
    u = d & ~m;
    case (k)
      2'd1:    return q | u;
      2'd2:    return q & ~u;
      2'd3:    return q ^ u;
      default: return (q & m) | u;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DIG; i++) dig_q[i] <= DIG_INIT[i*DW +: DW];
      for (int j = 0; j < N_ANA; j++) ana_q[j] <= ainit(j);
    end else if (wr) begin
      for (int i = 0; i < N_DIG; i++)
        if (dig_hit && dsel == DI_W'(i))
          dig_q[i] <= (dig_q[i] & DIG_MASK[i*DW +: DW]) | (wdata & ~DIG_MASK[i*DW +: DW]);
      for (int j = 0; j < N_ANA; j++)
        if (ana_hit && asel == AR_W'(j))
          ana_q[j] <= anext(ana_q[j], amask(j), wdata, kind);
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_DIG; i++)
      if (dig_hit && dsel == DI_W'(i)) rdata = dig_q[i];
    for (int j = 0; j < N_ANA; j++)
      if (ana_hit && asel == AR_W'(j)) rdata = ana_q[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= req && !(dig_hit || ana_hit);
  end
endmodule

// File: rtl/regbank_sct_chk.sv
`timescale 1ns/1ps
module regbank_sct_chk #(
  parameter int DW       = 32,
  parameter int ADDR_W   = 15,
  parameter int N_DIG    = 8,
  parameter int N_ANA    = 6,
  parameter int N_PLL    = 3,
  parameter int LOCK_BIT = 31,
  parameter logic [N_DIG*DW-1:0] DIG_MASK = '0,
  parameter logic [N_ANA*DW-1:0] ANA_MASK = '0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req,
  input logic                     we,
  input logic [ADDR_W-1:0]        addr,
  input logic [DW-1:0]            rdata,
  input logic                     err,
  input logic [N_DIG-1:0][DW-1:0] dig_q,
  input logic [N_ANA-1:0][DW-1:0] ana_q
);
  localparam int DI_W = ADDR_W - 3;
  localparam int AR_W = ADDR_W - 5;
  localparam logic [DI_W-1:0] NDL = DI_W'(N_DIG);
  localparam logic [AR_W-1:0] NAL = AR_W'(N_ANA);

  wire unmapped = addr[ADDR_W-1] ? (addr[ADDR_W-2:4] >= NAL) : (addr[ADDR_W-2:2] >= NDL);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> rdata == '0);

  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && unmapped) |=> err);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && unmapped) |=> !err);

  p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && we) |=> ($stable(dig_q) && $stable(ana_q)));

  p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && unmapped) |=> ($stable(dig_q) && $stable(ana_q)));

  for (genvar i = 0; i < N_DIG; i++) begin : g_dig
    p_dig_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(dig_q[i] & DIG_MASK[i*DW +: DW]));
  end

  for (genvar j = 0; j < N_ANA; j++) begin : g_ana
    p_ana_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ana_q[j] & ANA_MASK[j*DW +: DW]));
  end

  for (genvar j = 0; j < N_PLL; j++) begin : g_pll
    p_lock_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ana_q[j][LOCK_BIT]);
  end
endmodule

bind regbank_sct regbank_sct_chk #(
  .DW(DW), .ADDR_W(ADDR_W), .N_DIG(N_DIG), .N_ANA(N_ANA), .N_PLL(N_PLL),
  .LOCK_BIT(LOCK_BIT), .DIG_MASK(DIG_MASK), .ANA_MASK(ANA_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
  .rdata(rdata), .err(err), .dig_q(dig_q), .ana_q(ana_q)
);

// File: tb/regbank_sct_tb.sv
`timescale 1ns/1ps
module regbank_sct_tb;
  localparam int ND = 8;
  localparam int NA = 6;
  localparam int NP = 3;
  localparam logic [31:0] LK = 32'h8000_0000;
  localparam logic [ND*32-1:0] B_DI = {32'h0000_0000, 32'h0BAD_F00D, 32'h1357_9BDF,
    32'h0000_00A5, 32'h2468_ACE0, 32'h0F0F_0000, 32'hCAFE_0123, 32'h0000_0010};
  localparam logic [ND*32-1:0] B_DM = {32'h0000_0000, 32'h7E7E_7E7E, 32'h8000_0001,
    32'hFF00_00FF, 32'h1234_8001, 32'h0000_FFFF, 32'hA5A5_0F0F, 32'hFFFF_FFFF};
  localparam logic [NA*32-1:0] B_AI = {32'h0000_0000, 32'h1A2B_3C4D, 32'h0C0C_0C0C,
    32'h0001_1006, 32'h0000_2000, 32'h0001_2345};
  localparam logic [NA*32-1:0] B_AM = {32'h0000_0000, 32'hFFFF_FFFF, 32'h4040_4040,
    32'h0000_00FF, 32'hFF00_0000, 32'hFFF0_0F00};

  logic clk = 0, rst_n = 0, req = 0, we = 0, err;
  logic [14:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] md [ND];
  logic [31:0] ma [NA];

  always #2 clk = ~clk;

  regbank_sct #(.N_DIG(ND), .N_ANA(NA), .N_PLL(NP), .LOCK_BIT(31),
    .DIG_INIT(B_DI), .DIG_MASK(B_DM), .ANA_INIT(B_AI), .ANA_MASK(B_AM)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err));

  function automatic logic [14:0] da(int i);
    return {1'b0, i[11:0], 2'b00};
  endfunction
  function automatic logic [14:0] aa(int j, int k);
    return {1'b1, j[9:0], k[1:0], 2'b00};
  endfunction
  function automatic logic [31:0] emask(int j);
    return B_AM[j*32 +: 32] | ((j < NP) ? LK : 32'h0);
  endfunction
  function automatic bit unm(logic [14:0] a);
    return a[14] ? (int'(a[13:4]) >= NA) : (int'(a[13:2]) >= ND);
  endfunction
  function automatic logic [31:0] mread(logic [14:0] a);
    if (unm(a)) return 32'h0;
    return a[14] ? ma[int'(a[13:4])] : md[int'(a[13:2])];
  endfunction

  task automatic mwrite(logic [14:0] a, logic [31:0] d);
    logic [31:0] m, u;
    int j;
    if (unm(a)) return;
    if (!a[14]) begin
      j = int'(a[13:2]);
      m = B_DM[j*32 +: 32];
      md[j] = (md[j] & m) | (d & ~m);
    end else begin
      j = int'(a[13:4]);
      m = emask(j);
      u = d & ~m;
      case (a[3:2])
        2'd0: ma[j] = (ma[j] & m) | u;
        2'd1: ma[j] = ma[j] | u;
        2'd2: ma[j] = ma[j] & ~u;
        default: ma[j] = ma[j] ^ u;
      endcase
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(bit r, bit w, logic [14:0] a, logic [31:0] d, string rtag);
    bit e;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d;
    #1;
    chk(rtag, rdata, mread(a));
    @(posedge clk);
    e = r && unm(a);
    if (r && w) mwrite(a, d);
    #1;
    chk("R10", {31'b0, err}, {31'b0, e});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < ND; i++) md[i] = B_DI[i*32 +: 32];
    for (int j = 0; j < NA; j++) ma[j] = B_AI[j*32 +: 32] | ((j < NP) ? LK : 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10", {31'b0, err}, 32'h0);

    for (int i = 0; i < ND; i++) acc(1, 0, da(i), 0, "R2");
    for (int j = 0; j < NA; j++) acc(1, 0, aa(j, 0), 0, "R2");
    for (int j = 0; j < NA; j++) acc(1, 0, aa(j, 1 + j % 3), 0, "R7");

    acc(1, 1, da(0), 32'h0000_0000, "R11");
    acc(1, 0, da(0), 0, "R3");
    acc(1, 1, da(7), 32'h5A5A_C3C3, "R11");
    acc(1, 0, da(7), 0, "R3");
    acc(1, 1, da(1), 32'hFFFF_FFFF, "R11");
    acc(1, 0, da(1), 0, "R3");

    acc(1, 1, aa(5, 1), 32'h0000_00F0, "R11");
    acc(1, 0, aa(5, 0), 0, "R4");
    acc(1, 1, aa(5, 2), 32'h0000_0030, "R11");
    acc(1, 0, aa(5, 0), 0, "R5");
    acc(1, 1, aa(5, 3), 32'hFF00_0011, "R11");
    acc(1, 0, aa(5, 0), 0, "R6");
    acc(1, 1, aa(4, 3), 32'hFFFF_FFFF, "R11");
    acc(1, 0, aa(4, 0), 0, "R3");

    acc(1, 1, aa(0, 2), 32'hFFFF_FFFF, "R11");
    acc(1, 0, aa(0, 0), 0, "R8");
    acc(1, 1, aa(1, 0), 32'h0000_0000, "R11");
    acc(1, 0, aa(1, 0), 0, "R8");
    acc(1, 1, aa(2, 3), 32'h8000_0000, "R11");
    acc(1, 0, aa(2, 0), 0, "R8");

    acc(1, 0, aa(NA, 0), 0, "R9");
    acc(1, 1, da(ND), 32'hFFFF_FFFF, "R9");
    acc(1, 0, 15'h7FFC, 0, "R9");
    acc(0, 0, 15'h7FFC, 0, "R9");
    acc(1, 0, {1'b0, 12'd3, 2'b11}, 0, "R1");
    acc(0, 1, da(7), 32'h1111_1111, "R12");
    acc(1, 0, da(7), 0, "R12");

    for (int n = 0; n < 600; n++) begin
      bit g, w, r;
      int idx, k;
      logic [14:0] a;
      logic [31:0] d;
      g = $urandom_range(0, 1) == 1;
      idx = g ? $urandom_range(0, NA + 2) : $urandom_range(0, ND + 3);
      k = $urandom_range(0, 3);
      a = g ? aa(idx, k) : da(idx);
      if ($urandom_range(0, 19) == 0) a = {g, 12'hFFF, 2'b00};
      d = $urandom;
      w = $urandom_range(0, 1) == 1;
      r = $urandom_range(0, 9) != 0;
      if (!w) begin
        acc(r, 0, a, d, unm(a) ? "R9" : (a[14] && a[3:2] != 0) ? "R7" : "R1");
      end else begin
        acc(r, 1, a, d, "R11");
        if (unm(a)) acc(1, 0, a, 0, "R9");
        else if (!r) acc(1, 0, a, 0, "R12");
        else if (!a[14] || a[3:2] == 0) acc(1, 0, a, 0, "R3");
        else if (a[3:2] == 1) acc(1, 0, a, 0, "R4");
        else if (a[3:2] == 2) acc(1, 0, a, 0, "R5");
        else acc(1, 0, a, 0, "R6");
      end
    end

    for (int j = 0; j < NP; j++) acc(1, 0, aa(j, 0), 0, "R8");
    for (int i = 0; i < ND; i++) acc(1, 0, da(i), 0, "R3");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule